// File: doc/BRIEF.md
# Strobed Handshake Port Pair

This block gives a parallel interface two independent 8-bit data ports, called group A and group B. Each port moves data in one direction under a strobe handshake with a peripheral. The direction is chosen by configuration. Three lines of a shared 8-bit control port carry each group's handshake: a peripheral strobe or acknowledge input, a buffer-full output and an interrupt request output.

As an input port, the group captures the peripheral's data while the strobe is held low. It then raises buffer-full, and it raises an interrupt once the strobe is released. A CPU read takes the data and clears both flags. As an output port, a CPU write latches data onto the port pins and pulls the active-low buffer-full line. The peripheral acknowledges with a low pulse on the acknowledge line. When the acknowledge returns high, the interrupt rises so the CPU can send the next byte.

Each group has an interrupt-enable flag. The CPU writes this flag with single-bit set/reset commands addressed by control-port line number. The strobe and acknowledge pins are asynchronous and pass through a synchronizer. Every flag change is driven by an edge found by comparing a signal with its registered previous value.

Top module: `hsk_port_duo`

## Requirements
- R1: After reset, and while a group's enable (`cfg_en_a`/`cfg_en_b`) is 0, that group drives no control-port line and its data port output enable is 0.
- R2: With `cfg_in`=1 (input), a low level on the strobe line (bit 4 for group A, bit 2 for group B) copies the port pins into `rdata` on every cycle the synchronized strobe is low. It also sets buffer-full high on bit 5 (A) or bit 1 (B). Pin changes while the strobe is high leave `rdata` unchanged.
- R3: Input buffer-full stays high while a CPU read (`rd` high) is in progress. It is cleared on the cycle after `rd` returns low.
- R4: The input interrupt on bit 3 (A) or bit 0 (B) is high when the strobe is high, buffer-full is high and the interrupt enable is 1. It is low from the first cycle of a CPU read.
- R5: A set/reset command (`bsr_we`=1, `bsr_sel`=line, `bsr_val`=new value) writes the interrupt enable. The line is 4 for group A input, 6 for group A output, and 2 for group B. Commands to any other line leave the enable unchanged. With the enable at 0, no interrupt is raised.
- R6: With `cfg_in`=0 (output), the data written while `wr` is high appears on the port pins with output enable 1. Active-low buffer-full on bit 7 (A) or bit 1 (B) goes low on the cycle after `wr` falls. It stays high while `wr` is still high, and returns high once the acknowledge line (bit 6 for A, bit 2 for B) is seen low.
- R7: The output interrupt on bit 3 (A) or bit 0 (B) is high when the acknowledge is high, buffer-full is released (high) and the enable is 1. It is low from the first cycle of a CPU write.
- R8: Strobe and acknowledge pins are synchronized. The buffer-full flag reacts at the third rising clock edge after the pin changes, and not before.
- R9: Enabling a group, or changing its direction, clears input buffer-full, the interrupt and the interrupt enable, and releases output buffer-full (high).
- R10: `pc_view` shows, for each control-port line, the value the block drives when that line is a handshake output, and the pin value otherwise.
- R11: If a new strobe falls in the same cycle that a CPU read ends, input buffer-full stays set and the new data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_a | input | 1 | Group A strobed mode enable |
| cfg_in_a | input | 1 | Group A direction, 1 = input |
| cfg_en_b | input | 1 | Group B strobed mode enable |
| cfg_in_b | input | 1 | Group B direction, 1 = input |
| rd_a | input | 1 | CPU read of group A active (high) |
| wr_a | input | 1 | CPU write to group A active (high) |
| rd_b | input | 1 | CPU read of group B active (high) |
| wr_b | input | 1 | CPU write to group B active (high) |
| cpu_wdata | input | W | CPU write data |
| bsr_we | input | 1 | Single-bit set/reset command strobe |
| bsr_sel | input | 3 | Control-port line addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| pa_in | input | W | Group A data pins in |
| pa_out | output | W | Group A data pins out |
| pa_oe | output | 1 | Group A data output enable |
| rdata_a | output | W | Group A input latch, read by the CPU |
| pb_in | input | W | Group B data pins in |
| pb_out | output | W | Group B data pins out |
| pb_oe | output | 1 | Group B data output enable |
| rdata_b | output | W | Group B input latch, read by the CPU |
| pc_in | input | 8 | Control-port pins in |
| pc_out | output | 8 | Control-port values driven |
| pc_oe | output | 8 | Control-port per-line output enable |
| pc_view | output | 8 | Control-port readback |

## Verification
The bench builds the block with its defaults: W=8 and SYNC_STAGES=2. With a two-flop synchronizer the pin-to-flag delay is a fixed three edges, so the bench can check the flag on both sides of that edge. It can also place a read end on exactly the cycle a new strobe is detected. Both groups are instantiated with their own line maps, so the bench reaches group B's shared strobe/acknowledge line and its single enable line, as well as group A's direction-dependent enable line.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int PC_W  = 8;
    localparam int SEL_W = 3;
    localparam int N_GRP = 2;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } hs_dir_e;

    typedef struct packed {
        logic inte;
        logic intr;
        logic obf_n;
        logic ibf;
    } hs_flags_t;

    localparam hs_flags_t FLAGS_IDLE = '{inte: 1'b0, intr: 1'b0, obf_n: 1'b1, ibf: 1'b0};

    // control-port line map per group (0 = A, 1 = B)
    function automatic logic [SEL_W-1:0] strobe_line(input int g);
        return (g == 0) ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [SEL_W-1:0] full_in_line(input int g);
        return (g == 0) ? 3'd5 : 3'd1;
    endfunction

    function automatic logic [SEL_W-1:0] ack_line(input int g);
        return (g == 0) ? 3'd6 : 3'd2;
    endfunction

    function automatic logic [SEL_W-1:0] full_out_line(input int g);
        return (g == 0) ? 3'd7 : 3'd1;
    endfunction

    function automatic logic [SEL_W-1:0] irq_line(input int g);
        return (g == 0) ? 3'd3 : 3'd0;
    endfunction

    function automatic logic [SEL_W-1:0] inte_in_line(input int g);
        return (g == 0) ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [SEL_W-1:0] inte_out_line(input int g);
        return (g == 0) ? 3'd6 : 3'd2;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{INIT}};
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/hsk_edge.sv
module hsk_edge #(
    parameter int           W    = 1,
    parameter logic [W-1:0] POL  = '0,   // 1: rising, 0: falling per bit
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] evt
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= INIT;
        else     q <= d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (POL[i]) begin : g_rise
            assign evt[i] = d[i] & ~q[i];
        end else begin : g_fall
            assign evt[i] = ~d[i] & q[i];
        end
    end

endmodule

// File: rtl/hsk_chan.sv
module hsk_chan
    import hsk_pkg::*;
#(
    parameter int               W            = 8,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [SEL_W-1:0] INTE_IN_BIT  = 3'd4,
    parameter logic [SEL_W-1:0] INTE_OUT_BIT = 3'd6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir_in,
    input  logic             rd,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             bsr_we,
    input  logic [SEL_W-1:0] bsr_sel,
    input  logic             bsr_val,
    input  logic [1:0]       hs_pins,   // [0] strobe, [1] acknowledge
    input  logic [W-1:0]     port_in,
    output logic [W-1:0]     port_out,
    output logic             port_oe,
    output logic [W-1:0]     rdata,
    output logic             bf_pin,
    output logic             irq_pin
);

    // synchronized handshake pins
    logic [1:0] hs_s;
    hsk_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (hs_pins),
        .dout (hs_s)
    );

    logic [1:0] hs_fall;
    hsk_edge #(.W(2), .POL(2'b00), .INIT(2'b11)) u_hs_edge (
        .clk (clk),
        .rst (rst),
        .d   (hs_s),
        .evt (hs_fall)
    );

    // CPU strobe edges: [3] write start, [2] write end, [1] read start, [0] read end
    logic [3:0] cpu_evt;
    hsk_edge #(.W(4), .POL(4'b1010), .INIT(4'b0000)) u_cpu_edge (
        .clk (clk),
        .rst (rst),
        .d   ({wr, wr, rd, rd}),
        .evt (cpu_evt)
    );

    logic stb_s, ack_s, stb_fall, ack_fall;
    logic wr_start, wr_end, rd_start, rd_end;
    assign stb_s    = hs_s[0];
    assign ack_s    = hs_s[1];
    assign stb_fall = hs_fall[0];
    assign ack_fall = hs_fall[1];
    assign wr_start = cpu_evt[3];
    assign wr_end   = cpu_evt[2];
    assign rd_start = cpu_evt[1];
    assign rd_end   = cpu_evt[0];

    // configuration tracking for mode entry
    hs_dir_e dir_e;
    logic    en_q, dir_q, entry, act_in, act_out;
    logic [SEL_W-1:0] inte_bit;

    assign dir_e    = hs_dir_e'(dir_in);
    assign entry    = en && (!en_q || (dir_q != dir_in));
    assign act_in   = en && (dir_e == DIR_IN);
    assign act_out  = en && (dir_e == DIR_OUT);
    assign inte_bit = (dir_e == DIR_IN) ? INTE_IN_BIT : INTE_OUT_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            en_q  <= en;
            dir_q <= dir_in;
        end
    end

    // handshake flags
    hs_flags_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (!en || entry) begin
            nxt = FLAGS_IDLE;
        end else begin
            if (bsr_we && (bsr_sel == inte_bit)) begin
                nxt.inte = bsr_val;
            end
            if (act_in) begin
                if (rd_end)   nxt.ibf = 1'b0;
                if (stb_fall) nxt.ibf = 1'b1;
                nxt.intr = nxt.ibf & stb_s & nxt.inte & ~rd;
            end else begin
                if (ack_fall) nxt.obf_n = 1'b1;
                if (wr_end)   nxt.obf_n = 1'b0;
                nxt.intr = nxt.obf_n & ack_s & nxt.inte & ~wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= FLAGS_IDLE;
        else     cur <= nxt;
    end

    // data latches
    logic [W-1:0] in_lat, out_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_lat  <= '0;
            out_lat <= '0;
        end else begin
            if (act_in && !stb_s) in_lat  <= port_in;
            if (act_out && wr)    out_lat <= wdata;
        end
    end

    assign port_out = out_lat;
    assign port_oe  = act_out;
    assign rdata    = in_lat;
    assign bf_pin   = (dir_e == DIR_IN) ? cur.ibf : cur.obf_n;
    assign irq_pin  = cur.intr;

    // checks
    p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
        (act_in && !entry && stb_fall) |=> cur.ibf);

    p_ibf_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (act_in && !entry && rd_end && !stb_fall) |=> !cur.ibf);

    p_irq_drop_rd_r4: assert property (@(posedge clk) disable iff (rst)
        (act_in && rd_start) |=> !cur.intr);

    p_obf_low_r6: assert property (@(posedge clk) disable iff (rst)
        (act_out && !entry && wr_end) |=> !cur.obf_n);

    p_irq_drop_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (act_out && wr_start) |=> !cur.intr);

    p_entry_idle_r9: assert property (@(posedge clk) disable iff (rst)
        entry |=> (!cur.ibf && cur.obf_n && !cur.intr && !cur.inte));

endmodule

// File: rtl/hsk_port_duo.sv
module hsk_port_duo
    import hsk_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en_a,
    input  logic             cfg_in_a,
    input  logic             cfg_en_b,
    input  logic             cfg_in_b,
    input  logic             rd_a,
    input  logic             wr_a,
    input  logic             rd_b,
    input  logic             wr_b,
    input  logic [W-1:0]     cpu_wdata,
    input  logic             bsr_we,
    input  logic [2:0]       bsr_sel,
    input  logic             bsr_val,
    input  logic [W-1:0]     pa_in,
    output logic [W-1:0]     pa_out,
    output logic             pa_oe,
    output logic [W-1:0]     rdata_a,
    input  logic [W-1:0]     pb_in,
    output logic [W-1:0]     pb_out,
    output logic             pb_oe,
    output logic [W-1:0]     rdata_b,
    input  logic [7:0]       pc_in,
    output logic [7:0]       pc_out,
    output logic [7:0]       pc_oe,
    output logic [7:0]       pc_view
);

    logic [N_GRP-1:0] grp_en, grp_dir, grp_rd, grp_wr, grp_bf, grp_irq, grp_poe;
    logic [W-1:0]     grp_pin   [N_GRP];
    logic [W-1:0]     grp_pout  [N_GRP];
    logic [W-1:0]     grp_rdata [N_GRP];

    assign grp_en  = {cfg_en_b, cfg_en_a};
    assign grp_dir = {cfg_in_b, cfg_in_a};
    assign grp_rd  = {rd_b, rd_a};
    assign grp_wr  = {wr_b, wr_a};
    assign grp_pin[0] = pa_in;
    assign grp_pin[1] = pb_in;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        hsk_chan #(
            .W            (W),
            .SYNC_STAGES  (SYNC_STAGES),
            .INTE_IN_BIT  (inte_in_line(g)),
            .INTE_OUT_BIT (inte_out_line(g))
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (grp_en[g]),
            .dir_in   (grp_dir[g]),
            .rd       (grp_rd[g]),
            .wr       (grp_wr[g]),
            .wdata    (cpu_wdata),
            .bsr_we   (bsr_we),
            .bsr_sel  (bsr_sel),
            .bsr_val  (bsr_val),
            .hs_pins  ({pc_in[ack_line(g)], pc_in[strobe_line(g)]}),
            .port_in  (grp_pin[g]),
            .port_out (grp_pout[g]),
            .port_oe  (grp_poe[g]),
            .rdata    (grp_rdata[g]),
            .bf_pin   (grp_bf[g]),
            .irq_pin  (grp_irq[g])
        );
    end

    assign pa_out  = grp_pout[0];
    assign pb_out  = grp_pout[1];
    assign pa_oe   = grp_poe[0];
    assign pb_oe   = grp_poe[1];
    assign rdata_a = grp_rdata[0];
    assign rdata_b = grp_rdata[1];

    // control-port line assembly
    always_comb begin
        pc_out = '0;
        pc_oe  = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (grp_en[g]) begin
                if (grp_dir[g]) begin
                    pc_oe[full_in_line(g)]  = 1'b1;
                    pc_out[full_in_line(g)] = grp_bf[g];
                end else begin
                    pc_oe[full_out_line(g)]  = 1'b1;
                    pc_out[full_out_line(g)] = grp_bf[g];
                end
                pc_oe[irq_line(g)]  = 1'b1;
                pc_out[irq_line(g)] = grp_irq[g];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PC_W; i++) begin
            pc_view[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
        end
    end

endmodule

// File: tb/hsk_port_duo_bench.sv
module hsk_port_duo_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en_a = 0, cfg_in_a = 0, cfg_en_b = 0, cfg_in_b = 0;
    logic         rd_a = 0, wr_a = 0, rd_b = 0, wr_b = 0;
    logic [W-1:0] cpu_wdata = '0;
    logic         bsr_we = 0;
    logic [2:0]   bsr_sel = '0;
    logic         bsr_val = 0;
    logic [W-1:0] pa_drv = '0, pb_drv = '0;
    logic [7:0]   pc_drv = 8'hFF;
    logic [W-1:0] pa_out, pb_out, rdata_a, rdata_b;
    logic         pa_oe, pb_oe;
    logic [7:0]   pc_out, pc_oe, pc_view;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    hsk_port_duo #(.W(W), .SYNC_STAGES(2)) u_hsk_port_duo (
        .clk (clk), .rst (rst),
        .cfg_en_a (cfg_en_a), .cfg_in_a (cfg_in_a),
        .cfg_en_b (cfg_en_b), .cfg_in_b (cfg_in_b),
        .rd_a (rd_a), .wr_a (wr_a), .rd_b (rd_b), .wr_b (wr_b),
        .cpu_wdata (cpu_wdata),
        .bsr_we (bsr_we), .bsr_sel (bsr_sel), .bsr_val (bsr_val),
        .pa_in (pa_drv), .pa_out (pa_out), .pa_oe (pa_oe), .rdata_a (rdata_a),
        .pb_in (pb_drv), .pb_out (pb_out), .pb_oe (pb_oe), .rdata_b (rdata_b),
        .pc_in (pc_drv), .pc_out (pc_out), .pc_oe (pc_oe), .pc_view (pc_view)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bsr(input logic [2:0] sel, input logic val);
        bsr_we = 1; bsr_sel = sel; bsr_val = val;
        tick(1);
        bsr_we = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset pc_oe", pc_oe, 0);
        chk("R1 reset pa_oe", pa_oe, 0);
        chk("R1 reset pb_oe", pb_oe, 0);
        chk("R10 reset view", pc_view, 8'hFF);
    endtask

    task automatic t_in_a;
        cfg_en_a = 1; cfg_in_a = 1;
        tick(2);
        chk("R2 A input lines", pc_oe, 8'h28);
        chk("R2 A ibf idle", pc_out[5], 0);
        bsr(3'd4, 1);
        pa_drv = 8'h5A; pc_drv[4] = 0;
        tick(2);
        chk("R8 ibf before third edge", pc_out[5], 0);
        tick(1);
        chk("R8 ibf at third edge", pc_out[5], 1);
        pa_drv = 8'hC3;
        tick(2);
        pc_drv[4] = 1;
        tick(4);
        chk("R2 latch while strobe low", rdata_a, 8'hC3);
        chk("R4 A irq raised", pc_out[3], 1);
        chk("R10 view ibf line", pc_view[5], 1);
        chk("R10 view strobe pin", pc_view[4], 1);
        pa_drv = 8'h11;
        tick(3);
        chk("R2 pins ignored with strobe high", rdata_a, 8'hC3);
        rd_a = 1;
        tick(1);
        chk("R4 irq low at read start", pc_out[3], 0);
        chk("R3 ibf held at read start", pc_out[5], 1);
        tick(2);
        chk("R3 ibf held during read", pc_out[5], 1);
        rd_a = 0;
        tick(1);
        chk("R3 ibf cleared at read end", pc_out[5], 0);
        tick(3);
        chk("R4 irq stays low", pc_out[3], 0);
    endtask

    task automatic t_inte_a;
        bsr(3'd4, 0);
        bsr(3'd6, 1);
        bsr(3'd5, 1);
        pa_drv = 8'h44; pc_drv[4] = 0;
        tick(3);
        pc_drv[4] = 1;
        tick(4);
        chk("R5 ibf set with enable off", pc_out[5], 1);
        chk("R5 no irq, other lines ignored", pc_out[3], 0);
        bsr(3'd4, 1);
        chk("R5 irq after enable set", pc_out[3], 1);
        rd_a = 1; tick(2); rd_a = 0; tick(2);
        chk("R3 ibf cleared", pc_out[5], 0);
    endtask

    task automatic t_collide_a;
        pa_drv = 8'h22; pc_drv[4] = 0;
        tick(3);
        pc_drv[4] = 1;
        tick(4);
        chk("R11 ibf set first", pc_out[5], 1);
        rd_a = 1;
        tick(2);
        pa_drv = 8'h99; pc_drv[4] = 0;
        tick(2);
        rd_a = 0;
        tick(1);
        chk("R11 ibf kept on collision", pc_out[5], 1);
        pc_drv[4] = 1;
        tick(4);
        chk("R11 new data held", rdata_a, 8'h99);
        chk("R11 ibf still set", pc_out[5], 1);
        rd_a = 1; tick(2); rd_a = 0; tick(2);
    endtask

    task automatic t_out_a;
        cfg_in_a = 0;
        tick(2);
        chk("R9 A output lines", pc_oe, 8'h88);
        chk("R9 obf released on entry", pc_out[7], 1);
        tick(3);
        chk("R9 enable cleared on entry", pc_out[3], 0);
        bsr(3'd6, 1);
        chk("R7 irq ready for data", pc_out[3], 1);
        cpu_wdata = 8'hA5; wr_a = 1;
        tick(1);
        chk("R7 irq low at write start", pc_out[3], 0);
        chk("R6 obf high during write", pc_out[7], 1);
        wr_a = 0;
        tick(1);
        chk("R6 obf low after write", pc_out[7], 0);
        chk("R6 A data on pins", pa_out, 8'hA5);
        chk("R6 A data enabled", pa_oe, 1);
        chk("R7 irq low while full", pc_out[3], 0);
        pc_drv[6] = 0;
        tick(2);
        chk("R8 obf before third edge", pc_out[7], 0);
        tick(1);
        chk("R6 obf released by ack", pc_out[7], 1);
        chk("R10 view ack pin", pc_view[6], 0);
        chk("R10 view obf line", pc_view[7], 1);
        chk("R7 irq low while ack low", pc_out[3], 0);
        pc_drv[6] = 1;
        tick(3);
        chk("R7 irq after ack release", pc_out[3], 1);
    endtask

    task automatic t_grp_b;
        cfg_en_b = 1; cfg_in_b = 1;
        tick(2);
        chk("R2 B input lines added", pc_oe, 8'h8B);
        bsr(3'd2, 1);
        pb_drv = 8'h3C; pc_drv[2] = 0;
        tick(3);
        chk("R2 B ibf set", pc_out[1], 1);
        pc_drv[2] = 1;
        tick(4);
        chk("R2 B data latched", rdata_b, 8'h3C);
        chk("R4 B irq raised", pc_out[0], 1);
        chk("R5 A untouched by B line", pc_out[3], 1);
        cfg_in_b = 0;
        tick(2);
        chk("R9 B obf released on entry", pc_out[1], 1);
        chk("R9 B irq cleared on entry", pc_out[0], 0);
        bsr(3'd2, 1);
        chk("R7 B irq ready", pc_out[0], 1);
        cpu_wdata = 8'h7E; wr_b = 1;
        tick(1);
        wr_b = 0;
        tick(1);
        chk("R6 B data on pins", pb_out, 8'h7E);
        chk("R6 B data enabled", pb_oe, 1);
        chk("R6 B obf low", pc_out[1], 0);
        pc_drv[2] = 0;
        tick(3);
        chk("R6 B obf released", pc_out[1], 1);
        pc_drv[2] = 1;
        tick(3);
        chk("R7 B irq after ack", pc_out[0], 1);
        cfg_in_b = 1;
        tick(2);
        chk("R9 B irq cleared on turn", pc_out[0], 0);
        chk("R9 B ibf cleared on turn", pc_out[1], 0);
    endtask

    task automatic t_disable_a;
        cfg_en_a = 0;
        tick(2);
        chk("R1 A lines released", pc_oe & 8'hF8, 0);
        chk("R1 A data disabled", pa_oe, 0);
        chk("R10 view falls back to pin", pc_view[7], 1);
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        t_reset();
        t_in_a();
        t_inte_a();
        t_collide_a();
        t_out_a();
        t_grp_b();
        t_disable_a();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule